// File: doc/BRIEF.md
# Change-of-State Interrupt Detector

This block watches a group of asynchronous input lines, 24 isolated inputs and 8 TTL lines by default, and records which of them have changed level. It first brings each line into the clock domain through a synchronizer chain. It then compares each synchronized sample with the one from the cycle before. When a line moves in a direction that is enabled for its bank, the block sets a sticky status bit for that line. A single level interrupt stays high while any status bit is set.

The lines are grouped into banks of eight. Each bank has its own rising-edge enable and its own falling-edge enable, and all of these sit in one enable register. The register file decodes the addresses and hands the block per-byte write strobes for the status word. A handler reads the status word, services the lines, and writes the same word back. Every bit written as one is cleared. Writing zero leaves a bit alone. A clear that lands in the same cycle as a new edge on the same line does not lose that edge.

Top module: `cos_detector`

## Requirements
- R1: Status bit i follows `line_in[i]`. Bank b owns bits 8b to 8b+7, so byte 3 holds the TTL lines and bytes 0 to 2 hold the isolated inputs.
- R2: A qualifying change on `line_in` shows up in `sts_rdata` after the third rising clock edge that follows it (two synchronizer stages, then the status register), and not after the second.
- R3: In the enable register, bit b (b = 0..3) enables rising edges for bank b and bit 4+b enables falling edges for bank b. A direction that is not enabled never sets status.
- R4: A status write clears every bit written as 1 in each byte lane whose `sts_wr_be` bit is high. Bits written as 0, and lanes whose strobe is low, keep their value. Writing back a word that was read clears exactly the bits that were read as set.
- R5: If an enabled edge and a clear hit the same status bit in the same cycle, the bit ends up set.
- R6: Clearing a bank's enables stops new status bits in that bank, but bits already set stay set until they are cleared.
- R7: `irq` is high exactly when at least one status bit is set.
- R8: After reset, status, enables and `irq` are zero. No edge is reported for lines that were already high when reset ended, even if enables are written at once.
- R9: `en_rdata` returns the last value written with `en_wr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| line_in | input | 32 | Asynchronous lines being watched |
| sts_wr_be | input | 4 | Per-byte write strobes for the status word (all high for a word write) |
| sts_wdata | input | 32 | Status write data; a 1 clears that bit |
| en_wr | input | 1 | Write strobe for the enable register |
| en_wdata | input | 8 | Enable write data |
| sts_rdata | output | 32 | Sticky change status |
| en_rdata | output | 8 | Current enables |
| irq | output | 1 | Level interrupt, high while any status bit is set |

## Verification
The bench runs every line under each of the four enable modes, once rising and once falling, and checks one cycle early as well as on time. A design with a swapped rise/fall field, a wrong bank slice or an off-by-one latency fails at once. It writes a clear in the same cycle as a falling edge on a line that is already set; a design that gives priority to the clear drops that event. It also clears single byte lanes, writes zeros, and writes back a word that was read; a design that ignores the strobes or toggles bits instead of clearing them leaves the wrong residue. Finally it ends a reset while all lines are high and enables everything at once; a design without a warm-up window latches 32 spurious rising edges.

// File: rtl/cos_pkg.sv
package cos_pkg;
   // per-bank edge selection, unpacked from the enable register
   typedef struct packed {
      logic rise;
      logic fall;
   } edge_en_t;
endpackage

// File: rtl/cos_sync.sv
module cos_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] pipe [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe[0] <= '0;
      else        pipe[0] <= d;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pipe[s] <= '0;
         else        pipe[s] <= pipe[s-1];
      end
   end

   assign q = pipe[STAGES-1];
endmodule

// File: rtl/cos_bank.sv
module cos_bank
   import cos_pkg::*;
#(
   parameter int BANK_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              armed,
   input  logic [BANK_W-1:0] cur,
   input  edge_en_t          en,
   input  logic [BANK_W-1:0] clr,
   output logic [BANK_W-1:0] status
);
   logic [BANK_W-1:0] prev_q;
   logic [BANK_W-1:0] status_q;
   logic [BANK_W-1:0] rise, fall, hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= cur;
   end

   assign rise = cur & ~prev_q;
   assign fall = ~cur & prev_q;
   assign hit  = armed ? ((en.rise ? rise : '0) | (en.fall ? fall : '0)) : '0;

   // a fresh edge outranks a simultaneous clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) status_q <= '0;
      else        status_q <= (status_q & ~clr) | hit;
   end

   assign status = status_q;

   p_set_on_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (hit != '0) |=> ((status_q & $past(hit)) == $past(hit)));

   p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ((clr & ~hit) != '0) |=> ((status_q & $past(clr & ~hit)) == '0));

   p_no_spurious_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !armed |=> ((status_q & ~$past(status_q)) == '0));
endmodule

// File: rtl/cos_detector.sv
module cos_detector
   import cos_pkg::*;
#(
   parameter int NUM_BANKS   = 4,
   parameter int BANK_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_BANKS*BANK_W-1:0] line_in,
   input  logic [NUM_BANKS-1:0]      sts_wr_be,
   input  logic [NUM_BANKS*BANK_W-1:0] sts_wdata,
   input  logic                      en_wr,
   input  logic [2*NUM_BANKS-1:0]    en_wdata,
   output logic [NUM_BANKS*BANK_W-1:0] sts_rdata,
   output logic [2*NUM_BANKS-1:0]    en_rdata,
   output logic                      irq
);
   localparam int NLINES = NUM_BANKS * BANK_W;
   localparam int EN_W   = 2 * NUM_BANKS;
   localparam int WARM   = SYNC_STAGES + 1;
   localparam int CW     = $clog2(WARM + 1);

   if (NUM_BANKS < 1 || BANK_W < 1) begin : g_bad_shape
      $error("cos_detector: NUM_BANKS and BANK_W must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("cos_detector: SYNC_STAGES must be at least 2");
   end

   logic [NLINES-1:0] line_s;
   logic [EN_W-1:0]   en_q;
   logic [CW-1:0]     warm_q;
   logic              armed;
   logic [NLINES-1:0] sts;

   cos_sync #(.W(NLINES), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(line_in), .q(line_s)
   );

   // edge history is untrusted until the synchronizer and the
   // previous-sample register both hold real samples
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             warm_q <= '0;
      else if (warm_q != CW'(WARM)) warm_q <= warm_q + 1'b1;
   end
   assign armed = (warm_q == CW'(WARM));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     en_q <= '0;
      else if (en_wr) en_q <= en_wdata;
   end

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      edge_en_t          ben;
      logic [BANK_W-1:0] bclr;

      assign ben.rise = en_q[b];
      assign ben.fall = en_q[NUM_BANKS + b];
      assign bclr     = sts_wr_be[b] ? sts_wdata[b*BANK_W +: BANK_W] : '0;

      cos_bank #(.BANK_W(BANK_W)) u_bank (
         .clk    (clk),
         .rst_n  (rst_n),
         .armed  (armed),
         .cur    (line_s[b*BANK_W +: BANK_W]),
         .en     (ben),
         .clr    (bclr),
         .status (sts[b*BANK_W +: BANK_W])
      );
   end

   assign sts_rdata = sts;
   assign en_rdata  = en_q;
   assign irq       = |sts;

   p_quiet_when_disabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q == '0) |=> ((sts & ~$past(sts)) == '0));
endmodule

// File: tb/cos_detector_test.sv
`timescale 1ns/100ps
module cos_detector_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] line_in = '0;
   logic [3:0]  sts_wr_be = '0;
   logic [31:0] sts_wdata = '0;
   logic        en_wr = 1'b0;
   logic [7:0]  en_wdata = '0;
   logic [31:0] sts_rdata;
   logic [7:0]  en_rdata;
   logic        irq;

   int checks = 0;
   int errors = 0;

   cos_detector uut (
      .clk(clk), .rst_n(rst_n), .line_in(line_in),
      .sts_wr_be(sts_wr_be), .sts_wdata(sts_wdata),
      .en_wr(en_wr), .en_wdata(en_wdata),
      .sts_rdata(sts_rdata), .en_rdata(en_rdata), .irq(irq)
   );

   always #2.5 clk = ~clk;

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic chk(input string tag, input logic [31:0] exp);
      checks++;
      if (sts_rdata !== exp || irq !== (exp != 0)) begin
         errors++;
         $display("FAIL %s: status=%h irq=%b expected status=%h irq=%b",
                  tag, sts_rdata, irq, exp, (exp != 0));
      end
   endtask

   task automatic chk_en(input logic [7:0] exp);
      checks++;
      if (en_rdata !== exp) begin
         errors++;
         $display("FAIL R9: enables=%h expected %h", en_rdata, exp);
      end
   endtask

   task automatic wr_en(input logic [7:0] v);
      en_wdata = v; en_wr = 1'b1;
      tick(1);
      en_wr = 1'b0; en_wdata = '0;
   endtask

   task automatic wr_sts(input logic [3:0] be, input logic [31:0] d);
      sts_wr_be = be; sts_wdata = d;
      tick(1);
      sts_wr_be = '0; sts_wdata = '0;
   endtask

   task automatic summary;
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      summary();
      $finish;
   end

   initial begin
      logic [31:0] word;
      // R8: reset values
      tick(3);
      chk("R8 reset", 32'h0);
      chk_en(8'h00);
      rst_n = 1'b1;
      tick(5);

      // R1 R2 R3 R7: every line, every enable mode, both directions
      for (int mode = 0; mode < 4; mode++) begin
         logic [7:0] ev;
         ev = ((mode & 1) != 0 ? 8'h0F : 8'h00) | ((mode & 2) != 0 ? 8'hF0 : 8'h00);
         wr_en(ev);
         chk_en(ev);
         for (int ln = 0; ln < 32; ln++) begin
            line_in = 32'h1 << ln;
            tick(2);
            chk("R2 early", 32'h0);
            tick(1);
            chk("R1 R3 rise", ((mode & 1) != 0) ? (32'h1 << ln) : 32'h0);
            wr_sts(4'hF, 32'hFFFF_FFFF);
            line_in = 32'h0;
            tick(3);
            chk("R1 R3 fall", ((mode & 2) != 0) ? (32'h1 << ln) : 32'h0);
            wr_sts(4'hF, 32'hFFFF_FFFF);
         end
      end

      // R3: mixed per-bank enables (rise bank 1, fall bank 3)
      wr_en(8'h82);
      chk_en(8'h82);
      line_in = 32'hFFFF_FFFF; tick(3);
      chk("R3 bank rise", 32'h0000_FF00);
      line_in = 32'h0; tick(3);
      chk("R3 bank fall", 32'hFF00_FF00);
      wr_sts(4'hF, 32'hFFFF_FFFF);
      chk("R4 word clear", 32'h0);

      // R4: byte-lane clears, zero writes, write-back of read word
      wr_en(8'h0F);
      line_in = 32'hFFFF_FFFF; tick(3);
      chk("R4 setup", 32'hFFFF_FFFF);
      wr_sts(4'b0100, 32'hFFFF_FFFF);
      chk("R4 lane 2", 32'hFF00_FFFF);
      wr_sts(4'hF, 32'h0);
      chk("R4 zeros", 32'hFF00_FFFF);
      wr_sts(4'b0001, 32'hFFFF_FF5A);
      chk("R4 lane 0 partial", 32'hFF00_FFA5);
      word = sts_rdata;
      wr_sts(4'hF, word);
      chk("R4 write back", 32'h0);

      // R5: clear and edge on the same bit in the same cycle
      wr_en(8'hFF);
      line_in = 32'hFFFF_FFDF; tick(3);
      wr_sts(4'hF, 32'hFFFF_FFFF);
      line_in = 32'hFFFF_FFFF; tick(3);
      chk("R5 setup", 32'h0000_0020);
      line_in = 32'hFFFF_FFDF; tick(2);
      wr_sts(4'hF, 32'h0000_0020);
      chk("R5 set wins", 32'h0000_0020);
      wr_sts(4'hF, 32'h0000_0020);
      chk("R5 later clear", 32'h0);
      line_in = 32'h0; tick(3);
      wr_sts(4'hF, 32'hFFFF_FFFF);

      // R6: disabling keeps existing bits, blocks new ones
      line_in = 32'hFFFF_0000; tick(3);
      chk("R6 setup", 32'hFFFF_0000);
      wr_en(8'h00);
      line_in = 32'h0000_FFFF; tick(4);
      chk("R6 held", 32'hFFFF_0000);
      wr_sts(4'hF, 32'hFFFF_FFFF);
      chk("R6 cleared", 32'h0);

      // R8: reset with lines high, enables written right away
      rst_n = 1'b0;
      line_in = 32'hFFFF_FFFF;
      tick(2);
      chk("R8 reset again", 32'h0);
      chk_en(8'h00);
      rst_n = 1'b1;
      wr_en(8'hFF);
      tick(8);
      chk("R8 no spurious edge", 32'h0);
      line_in = 32'h0; tick(3);
      chk("R8 armed after warmup", 32'hFFFF_FFFF);

      summary();
      $finish;
   end
endmodule